// File: doc/BRIEF.md
# SD Host Command Status and Interrupt Unit

This unit is the register-side sequencing core of an SD/MMC host controller. Software programs a command word, a transfer-mode word and a block-size word through a simple single-cycle register port. An accepted command word raises a one-cycle start strobe toward the card-side engine, together with the decoded response length. The unit then tracks whether the command line and the data lines are still occupied, and reports this as two inhibit flags in a read-only present-state word.

The card-side engine reports events as one-cycle pulses: command done, transfer done, DMA boundary, buffer ready for write or read, DAT0 busy release and a vector of error causes. Each event is latched into a write-one-to-clear status word only when its status-enable bit is set. A read-only summary bit gathers all latched error causes. A signal-enable mask selects which latched bits drive the single interrupt line. A self-clearing software reset returns all programmable state to its reset values.

Register word index on `reg_addr`: 0 command, 1 transfer mode, 2 block size, 3 present state, 4 interrupt status, 5 status enable, 6 signal enable, 7 software reset. Reads are combinational from `reg_addr`. Writes take effect on the rising clock edge while `reg_wr` is high.

Top module: `sdhc_csu`

## Requirements
- R1: An accepted write to the command word (index 0) stores only bits 13:8 (command index), 5 (data present), 4 (index check), 3 (CRC check) and 1:0 (response type); all other bits read 0. On the next cycle `cmd_start` is high for exactly one cycle. At the same time `cmd_resp_len` shows 0 for type 00, 136 for type 01 and 48 for types 10 and 11, and `cmd_busy_chk` is high only for type 11.
- R2: The transfer-mode word (index 1) stores bits 0 (DMA enable), 1 (block count enable), 2 (auto stop enable), 4 (read direction) and 5 (multi-block); all other bits read 0.
- R3: The block-size word (index 2) stores the block size in bits 11:0 and the DMA boundary code in bits 14:12; all other bits read 0.
- R4: A command-word write while the command inhibit flag is set is ignored: no strobe is issued and the stored command word is unchanged.
- R5: Accepting a command sets the command inhibit flag (present-state bit 0). It also sets the data inhibit flag (bit 1) when data present is set or the response type is 11. Command done clears the command flag. Transfer done or busy release clears the data flag.
- R6: Present-state bits 23:20 follow `dat_lines[3:0]`, with DAT0 in bit 20.
- R7: Status (index 4) bit 0 latches command done, bit 1 transfer done, bit 3 DMA boundary, bit 4 write-buffer ready, bit 5 read-buffer ready, and bit 16+k error cause k (k = 0 is command timeout). An event latches only if the same bit is set in the status-enable word (index 5). That word keeps only the bits that exist.
- R8: Writing one to a status bit clears it. An event in the same cycle wins over the clear. Writing bit 15 has no effect.
- R9: Status bit 15 is high exactly while any latched error-cause bit (16 and up) is set.
- R10: `irq` is high while any status bit, bit 15 included, is set together with its bit in the signal-enable word (index 6).
- R11: Writing 1 to bit 0 of the reset word (index 7) makes that bit read 1 for RST_CYCLES cycles and then 0 by itself. All other state returns to its reset value, and register writes are ignored meanwhile.
- R12: After `rst_n` is released, all stored words, inhibit flags, status, `irq` and `cmd_start` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word index |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data of the addressed word |
| ev_cmd_done | input | 1 | Command finished on the line |
| ev_xfer_done | input | 1 | Data transfer finished |
| ev_dma_bnd | input | 1 | DMA boundary reached |
| ev_buf_wr_rdy | input | 1 | Write buffer ready |
| ev_buf_rd_rdy | input | 1 | Read buffer ready |
| ev_busy_release | input | 1 | DAT0 released after busy |
| ev_err | input | ERR_W | Error-cause pulses, bit 0 command timeout |
| dat_lines | input | 4 | Sampled DAT[3:0] levels |
| irq | output | 1 | Interrupt line |
| cmd_start | output | 1 | One-cycle command start strobe |
| cmd_resp_len | output | 8 | Decoded response length in bits |
| cmd_busy_chk | output | 1 | Busy check follows the response |

## Verification
The assertions check on every cycle the invariants that hold in any state. A start strobe only follows a free command line. The inhibit flags drop only after their release events or a software reset. No status bit rises without its enable. The interrupt stays low under an empty signal mask, and a running software reset keeps status and inhibits at zero. The bench scenarios show the things that depend on stored values and ordering. These are the response-length decode over several command words, the field masks, a command rejected under inhibit, the set-over-clear collision, the summary bit following its causes, and the reset bit timing out on its own.

// File: rtl/sdhc_csu_pkg.sv
package sdhc_csu_pkg;

   localparam int REG_AW = 3;

   localparam logic [REG_AW-1:0] A_CMD   = 3'd0;
   localparam logic [REG_AW-1:0] A_XFER  = 3'd1;
   localparam logic [REG_AW-1:0] A_BLK   = 3'd2;
   localparam logic [REG_AW-1:0] A_PRES  = 3'd3;
   localparam logic [REG_AW-1:0] A_STS   = 3'd4;
   localparam logic [REG_AW-1:0] A_STSEN = 3'd5;
   localparam logic [REG_AW-1:0] A_SIGEN = 3'd6;
   localparam logic [REG_AW-1:0] A_SRST  = 3'd7;

   // stored-bit masks of the programmable words
   localparam logic [15:0] CMD_MASK  = 16'h3F3B;
   localparam logic [15:0] XFER_MASK = 16'h0037;
   localparam logic [15:0] BLK_MASK  = 16'h7FFF;

   localparam int CMD_DATA_BIT = 5;

   // status bit positions
   localparam int ST_CMD_DONE  = 0;
   localparam int ST_XFER_DONE = 1;
   localparam int ST_DMA       = 3;
   localparam int ST_BUF_WR    = 4;
   localparam int ST_BUF_RD    = 5;
   localparam int ST_ERR_SUM   = 15;
   localparam int ST_ERR_BASE  = 16;

   localparam logic [31:0] NORM_MASK = 32'h0000_003B;

   // present-state positions
   localparam int PS_CMD_INH = 0;
   localparam int PS_DAT_INH = 1;
   localparam int PS_DAT_LO  = 20;

   typedef enum logic [1:0] {
      RSP_NONE     = 2'b00,
      RSP_L136     = 2'b01,
      RSP_L48      = 2'b10,
      RSP_L48_BUSY = 2'b11
   } rsp_kind_e;

   function automatic logic [7:0] rsp_len(input rsp_kind_e k);
      case (k)
         RSP_L136:              return 8'd136;
         RSP_L48, RSP_L48_BUSY: return 8'd48;
         default:               return 8'd0;
      endcase
   endfunction

endpackage

// File: rtl/sdhc_csu_soft_reset.sv
module sdhc_csu_soft_reset #(
   parameter int RST_CYCLES = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic req,
   output logic busy
);
   localparam int CNT_W = $clog2(RST_CYCLES + 1);

   if (RST_CYCLES < 1) begin : g_bad_len
      $error("sdhc_csu_soft_reset: RST_CYCLES must be at least 1");
   end

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (cnt_q != '0)
         cnt_q <= cnt_q - 1'b1;
      else if (req)
         cnt_q <= CNT_W'(RST_CYCLES);
   end

   assign busy = (cnt_q != '0);

endmodule

// File: rtl/sdhc_csu_cmd_path.sv
module sdhc_csu_cmd_path
   import sdhc_csu_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        srst,
   input  logic        wr_cmd,
   input  logic        wr_xfer,
   input  logic        wr_blk,
   input  logic [15:0] wdata,
   input  logic        ev_cmd_done,
   input  logic        ev_xfer_done,
   input  logic        ev_busy_release,
   output logic [15:0] cmd_q,
   output logic [15:0] xfer_q,
   output logic [15:0] blk_q,
   output logic        cmd_inh,
   output logic        dat_inh,
   output logic        cmd_start,
   output logic [7:0]  cmd_resp_len,
   output logic        cmd_busy_chk
);
   logic      accept;
   logic      need_dat;
   rsp_kind_e kind;

   assign accept   = wr_cmd & ~cmd_inh;
   assign kind     = rsp_kind_e'(wdata[1:0]);
   assign need_dat = wdata[CMD_DATA_BIT] | (kind == RSP_L48_BUSY);

   // command word, start strobe and decoded response
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmd_q        <= '0;
         cmd_start    <= 1'b0;
         cmd_resp_len <= '0;
         cmd_busy_chk <= 1'b0;
      end else if (srst) begin
         cmd_q        <= '0;
         cmd_start    <= 1'b0;
         cmd_resp_len <= '0;
         cmd_busy_chk <= 1'b0;
      end else begin
         cmd_start <= accept;
         if (accept) begin
            cmd_q        <= wdata & CMD_MASK;
            cmd_resp_len <= rsp_len(kind);
            cmd_busy_chk <= (kind == RSP_L48_BUSY);
         end
      end
   end

   // line occupancy flags
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmd_inh <= 1'b0;
         dat_inh <= 1'b0;
      end else if (srst) begin
         cmd_inh <= 1'b0;
         dat_inh <= 1'b0;
      end else begin
         if (accept)
            cmd_inh <= 1'b1;
         else if (ev_cmd_done)
            cmd_inh <= 1'b0;

         if (accept && need_dat)
            dat_inh <= 1'b1;
         else if (ev_xfer_done || ev_busy_release)
            dat_inh <= 1'b0;
      end
   end

   // transfer mode and block geometry
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         xfer_q <= '0;
         blk_q  <= '0;
      end else if (srst) begin
         xfer_q <= '0;
         blk_q  <= '0;
      end else begin
         if (wr_xfer) xfer_q <= wdata & XFER_MASK;
         if (wr_blk)  blk_q  <= wdata & BLK_MASK;
      end
   end

endmodule

// File: rtl/sdhc_csu_irq_status.sv
module sdhc_csu_irq_status
   import sdhc_csu_pkg::*;
#(
   parameter int ERR_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             srst,
   input  logic             wr_sts,
   input  logic             wr_sts_en,
   input  logic             wr_sig_en,
   input  logic [31:0]      wdata,
   input  logic             ev_cmd_done,
   input  logic             ev_xfer_done,
   input  logic             ev_dma_bnd,
   input  logic             ev_buf_wr_rdy,
   input  logic             ev_buf_rd_rdy,
   input  logic [ERR_W-1:0] ev_err,
   output logic [31:0]      status,
   output logic [31:0]      sts_en,
   output logic [31:0]      sig_en,
   output logic             irq
);
   localparam logic [31:0] ERR_FIELD  = ((32'h1 << ERR_W) - 32'h1) << ST_ERR_BASE;
   localparam logic [31:0] LATCH_MASK = NORM_MASK | ERR_FIELD;
   localparam logic [31:0] SIG_MASK   = LATCH_MASK | (32'h1 << ST_ERR_SUM);

   logic [31:0] ev_all;
   logic [31:0] lat_q;
   logic        err_any;

   always_comb begin
      ev_all                      = '0;
      ev_all[ST_CMD_DONE]         = ev_cmd_done;
      ev_all[ST_XFER_DONE]        = ev_xfer_done;
      ev_all[ST_DMA]              = ev_dma_bnd;
      ev_all[ST_BUF_WR]           = ev_buf_wr_rdy;
      ev_all[ST_BUF_RD]           = ev_buf_rd_rdy;
      ev_all[ST_ERR_BASE +: ERR_W] = ev_err;
   end

   for (genvar i = 0; i < 32; i++) begin : g_bit
      if (LATCH_MASK[i]) begin : g_flop
         logic bit_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               bit_q <= 1'b0;
            else if (srst)
               bit_q <= 1'b0;
            else if (ev_all[i] && sts_en[i])
               bit_q <= 1'b1;
            else if (wr_sts && wdata[i])
               bit_q <= 1'b0;
         end
         assign lat_q[i] = bit_q;
      end else begin : g_none
         assign lat_q[i] = 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sts_en <= '0;
         sig_en <= '0;
      end else if (srst) begin
         sts_en <= '0;
         sig_en <= '0;
      end else begin
         if (wr_sts_en) sts_en <= wdata & LATCH_MASK;
         if (wr_sig_en) sig_en <= wdata & SIG_MASK;
      end
   end

   assign err_any = |lat_q[31:ST_ERR_BASE];

   always_comb begin
      status             = lat_q;
      status[ST_ERR_SUM] = err_any;
   end

   assign irq = |(status & sig_en);

endmodule

// File: rtl/sdhc_csu.sv
module sdhc_csu
   import sdhc_csu_pkg::*;
#(
   parameter int ERR_W      = 8,
   parameter int RST_CYCLES = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic [2:0]        reg_addr,
   input  logic [31:0]       reg_wdata,
   output logic [31:0]       reg_rdata,
   input  logic              ev_cmd_done,
   input  logic              ev_xfer_done,
   input  logic              ev_dma_bnd,
   input  logic              ev_buf_wr_rdy,
   input  logic              ev_buf_rd_rdy,
   input  logic              ev_busy_release,
   input  logic [ERR_W-1:0]  ev_err,
   input  logic [3:0]        dat_lines,
   output logic              irq,
   output logic              cmd_start,
   output logic [7:0]        cmd_resp_len,
   output logic              cmd_busy_chk
);
   if (ERR_W < 1 || ERR_W > 16) begin : g_bad_err_w
      $error("sdhc_csu: ERR_W must lie in 1..16");
   end

   logic        srst_busy;
   logic        wr_ok;
   logic [15:0] cmd_q, xfer_q, blk_q;
   logic        cmd_inh, dat_inh;
   logic [31:0] status, sts_en, sig_en;
   logic [31:0] pres;

   assign wr_ok = reg_wr & ~srst_busy;

   sdhc_csu_soft_reset #(
      .RST_CYCLES(RST_CYCLES)
   ) u_srst (
      .clk  (clk),
      .rst_n(rst_n),
      .req  (wr_ok && (reg_addr == A_SRST) && reg_wdata[0]),
      .busy (srst_busy)
   );

   sdhc_csu_cmd_path u_cmd (
      .clk            (clk),
      .rst_n          (rst_n),
      .srst           (srst_busy),
      .wr_cmd         (wr_ok && (reg_addr == A_CMD)),
      .wr_xfer        (wr_ok && (reg_addr == A_XFER)),
      .wr_blk         (wr_ok && (reg_addr == A_BLK)),
      .wdata          (reg_wdata[15:0]),
      .ev_cmd_done    (ev_cmd_done),
      .ev_xfer_done   (ev_xfer_done),
      .ev_busy_release(ev_busy_release),
      .cmd_q          (cmd_q),
      .xfer_q         (xfer_q),
      .blk_q          (blk_q),
      .cmd_inh        (cmd_inh),
      .dat_inh        (dat_inh),
      .cmd_start      (cmd_start),
      .cmd_resp_len   (cmd_resp_len),
      .cmd_busy_chk   (cmd_busy_chk)
   );

   sdhc_csu_irq_status #(
      .ERR_W(ERR_W)
   ) u_irq (
      .clk          (clk),
      .rst_n        (rst_n),
      .srst         (srst_busy),
      .wr_sts       (wr_ok && (reg_addr == A_STS)),
      .wr_sts_en    (wr_ok && (reg_addr == A_STSEN)),
      .wr_sig_en    (wr_ok && (reg_addr == A_SIGEN)),
      .wdata        (reg_wdata),
      .ev_cmd_done  (ev_cmd_done),
      .ev_xfer_done (ev_xfer_done),
      .ev_dma_bnd   (ev_dma_bnd),
      .ev_buf_wr_rdy(ev_buf_wr_rdy),
      .ev_buf_rd_rdy(ev_buf_rd_rdy),
      .ev_err       (ev_err),
      .status       (status),
      .sts_en       (sts_en),
      .sig_en       (sig_en),
      .irq          (irq)
   );

   always_comb begin
      pres                      = '0;
      pres[PS_CMD_INH]          = cmd_inh;
      pres[PS_DAT_INH]          = dat_inh;
      pres[PS_DAT_LO +: 4]      = dat_lines;
   end

   always_comb begin
      case (reg_addr)
         A_CMD:   reg_rdata = {16'h0, cmd_q};
         A_XFER:  reg_rdata = {16'h0, xfer_q};
         A_BLK:   reg_rdata = {16'h0, blk_q};
         A_PRES:  reg_rdata = pres;
         A_STS:   reg_rdata = status;
         A_STSEN: reg_rdata = sts_en;
         A_SIGEN: reg_rdata = sig_en;
         A_SRST:  reg_rdata = {31'h0, srst_busy};
         default: reg_rdata = '0;
      endcase
   end

endmodule

// File: rtl/sdhc_csu_checks.sv
module sdhc_csu_checks (
   input logic        clk,
   input logic        rst_n,
   input logic        cmd_start,
   input logic        cmd_inh,
   input logic        dat_inh,
   input logic        ev_cmd_done,
   input logic        ev_xfer_done,
   input logic        ev_busy_release,
   input logic        srst_busy,
   input logic [31:0] status,
   input logic [31:0] sts_en,
   input logic [31:0] sig_en,
   input logic        irq
);
   // R4: a start strobe only follows a write seen while the command line was free
   a_r4_start_only_when_free: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_start |-> (cmd_inh && !$past(cmd_inh)));

   // R5: command inhibit drops only after command done or a software reset
   a_r5_cmd_inh_release: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(cmd_inh) |-> $past(ev_cmd_done || srst_busy));

   // R5: data inhibit drops only after transfer done, busy release or a software reset
   a_r5_dat_inh_release: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(dat_inh) |-> $past(ev_xfer_done || ev_busy_release || srst_busy));

   // R7: no latched status bit rises unless its enable was set
   a_r7_latch_gated: assert property (@(posedge clk) disable iff (!rst_n)
      ((status & ~$past(status) & ~$past(sts_en)) & 32'hFFFF_7FFF) == 32'h0);

   // R10: an empty signal mask keeps the interrupt low
   a_r10_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (sig_en == 32'h0) |-> !irq);

   // R11: a running software reset leaves status and inhibits at zero
   a_r11_srst_clears: assert property (@(posedge clk) disable iff (!rst_n)
      srst_busy |=> (status == 32'h0 && !cmd_inh && !dat_inh));

endmodule

bind sdhc_csu sdhc_csu_checks u_checks (
   .clk            (clk),
   .rst_n          (rst_n),
   .cmd_start      (cmd_start),
   .cmd_inh        (cmd_inh),
   .dat_inh        (dat_inh),
   .ev_cmd_done    (ev_cmd_done),
   .ev_xfer_done   (ev_xfer_done),
   .ev_busy_release(ev_busy_release),
   .srst_busy      (srst_busy),
   .status         (status),
   .sts_en         (sts_en),
   .sig_en         (sig_en),
   .irq            (irq)
);

// File: tb/sdhc_csu_test.sv
module sdhc_csu_test;
   localparam int CLK_PERIOD = 10;
   localparam int ERR_W      = 8;
   localparam int RST_CYCLES = 4;

   localparam logic [2:0] A_CMD = 3'd0, A_XFER = 3'd1, A_BLK = 3'd2, A_PRES = 3'd3,
                          A_STS = 3'd4, A_STSEN = 3'd5, A_SIGEN = 3'd6, A_SRST = 3'd7;
   localparam logic [31:0] LATCH_ALL = 32'h00FF_003B;

   // {command word, expected length, busy check, data inhibit, release by busy}
   localparam int NV = 6;
   localparam logic [26:0] VEC [NV] = '{
      {16'h0500, 8'd0,   1'b0, 1'b0, 1'b0},
      {16'h0209, 8'd136, 1'b0, 1'b0, 1'b0},
      {16'h1112, 8'd48,  1'b0, 1'b0, 1'b0},
      {16'h0C1B, 8'd48,  1'b1, 1'b1, 1'b1},
      {16'h1232, 8'd48,  1'b0, 1'b1, 1'b0},
      {16'hFFC6, 8'd48,  1'b0, 1'b0, 1'b0}
   };

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              reg_wr = 1'b0;
   logic [2:0]        reg_addr = '0;
   logic [31:0]       reg_wdata = '0;
   logic [31:0]       reg_rdata;
   logic              ev_cmd_done = 1'b0, ev_xfer_done = 1'b0, ev_dma_bnd = 1'b0;
   logic              ev_buf_wr_rdy = 1'b0, ev_buf_rd_rdy = 1'b0, ev_busy_release = 1'b0;
   logic [ERR_W-1:0]  ev_err = '0;
   logic [3:0]        dat_lines = 4'b1010;
   logic              irq, cmd_start, cmd_busy_chk;
   logic [7:0]        cmd_resp_len;

   int n_checks = 0;
   int n_fail   = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   sdhc_csu #(.ERR_W(ERR_W), .RST_CYCLES(RST_CYCLES)) uut (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .ev_cmd_done(ev_cmd_done), .ev_xfer_done(ev_xfer_done), .ev_dma_bnd(ev_dma_bnd),
      .ev_buf_wr_rdy(ev_buf_wr_rdy), .ev_buf_rd_rdy(ev_buf_rd_rdy),
      .ev_busy_release(ev_busy_release), .ev_err(ev_err), .dat_lines(dat_lines),
      .irq(irq), .cmd_start(cmd_start), .cmd_resp_len(cmd_resp_len),
      .cmd_busy_chk(cmd_busy_chk)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic wr(input logic [2:0] a, input logic [31:0] d);
      reg_addr  = a;
      reg_wdata = d;
      reg_wr    = 1'b1;
      step();
      reg_wr    = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [31:0] d);
      reg_addr = a;
      #1;
      d = reg_rdata;
   endtask

   task automatic rd_check(input string req, input logic [2:0] a, input logic [31:0] exp);
      logic [31:0] d;
      rd(a, d);
      check(req, d, exp);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

   initial begin
      logic [31:0] d;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R12: reset state
      rd_check("R12 cmd", A_CMD, 32'h0);
      rd_check("R12 xfer", A_XFER, 32'h0);
      rd_check("R12 blk", A_BLK, 32'h0);
      rd_check("R12 status", A_STS, 32'h0);
      rd_check("R12 sts_en", A_STSEN, 32'h0);
      check("R12 irq", {31'h0, irq}, 32'h0);
      check("R12 cmd_start", {31'h0, cmd_start}, 32'h0);
      // R6: DAT lines in present state, inhibits clear
      rd_check("R6 pres", A_PRES, 32'h00A0_0000);
      dat_lines = 4'b0101;
      rd_check("R6 pres dat0", A_PRES, 32'h0050_0000);

      // R7: enable mask keeps only existing bits
      wr(A_STSEN, 32'hFFFF_FFFF);
      rd_check("R7 sts_en mask", A_STSEN, LATCH_ALL);

      // R1 / R5: table of command words
      for (int i = 0; i < NV; i++) begin
         logic [15:0] cw;
         cw = VEC[i][26:11];
         wr(A_CMD, {16'h0, cw});
         check("R1 start", {31'h0, cmd_start}, 32'h1);
         check("R1 resp_len", {24'h0, cmd_resp_len}, {24'h0, VEC[i][10:3]});
         check("R1 busy_chk", {31'h0, cmd_busy_chk}, {31'h0, VEC[i][2]});
         rd_check("R1 cmd readback", A_CMD, {16'h0, cw & 16'h3F3B});
         rd_check("R5 inhibit set", A_PRES, {8'h0, 4'b0101, 18'h0, VEC[i][1], 1'b1});
         step();
         check("R1 start one cycle", {31'h0, cmd_start}, 32'h0);
         ev_cmd_done = 1'b1; step(); ev_cmd_done = 1'b0;
         rd_check("R5 cmd inhibit clear", A_PRES, {8'h0, 4'b0101, 18'h0, VEC[i][1], 1'b0});
         rd_check("R7 cmd done latched", A_STS, 32'h1);
         if (VEC[i][1]) begin
            if (VEC[i][0]) begin
               ev_busy_release = 1'b1; step(); ev_busy_release = 1'b0;
            end else begin
               ev_xfer_done = 1'b1; step(); ev_xfer_done = 1'b0;
            end
            rd_check("R5 dat inhibit clear", A_PRES, 32'h0050_0000);
         end
         wr(A_STS, 32'hFFFF_FFFF);
         rd_check("R8 w1c all", A_STS, 32'h0);
      end

      // R4: command write ignored under inhibit
      wr(A_CMD, 32'h0000_0510);
      step();
      wr(A_CMD, 32'h0000_0801);
      check("R4 no start", {31'h0, cmd_start}, 32'h0);
      rd_check("R4 cmd kept", A_CMD, 32'h0000_0510);
      ev_cmd_done = 1'b1; step(); ev_cmd_done = 1'b0;
      wr(A_STS, 32'hFFFF_FFFF);

      // R2 / R3: field masks
      wr(A_XFER, 32'h0000_FFFF);
      rd_check("R2 xfer mask", A_XFER, 32'h0000_0037);
      wr(A_XFER, 32'h0000_0011);
      rd_check("R2 xfer value", A_XFER, 32'h0000_0011);
      wr(A_BLK, 32'hFFFF_F200);
      rd_check("R3 blk mask", A_BLK, 32'h0000_7200);

      // R7: disabled events are not latched
      wr(A_STSEN, 32'h0000_0001);
      ev_xfer_done = 1'b1; ev_dma_bnd = 1'b1; ev_buf_rd_rdy = 1'b1; step();
      ev_xfer_done = 1'b0; ev_dma_bnd = 1'b0; ev_buf_rd_rdy = 1'b0;
      rd_check("R7 disabled ignored", A_STS, 32'h0);
      wr(A_STSEN, LATCH_ALL);
      ev_dma_bnd = 1'b1; ev_buf_wr_rdy = 1'b1; ev_buf_rd_rdy = 1'b1; step();
      ev_dma_bnd = 1'b0; ev_buf_wr_rdy = 1'b0; ev_buf_rd_rdy = 1'b0;
      rd_check("R7 bit positions", A_STS, 32'h0000_0038);

      // R8: set wins over simultaneous clear
      ev_dma_bnd = 1'b1; reg_addr = A_STS; reg_wdata = 32'h8; reg_wr = 1'b1;
      step();
      ev_dma_bnd = 1'b0; reg_wr = 1'b0;
      rd_check("R8 set wins", A_STS, 32'h0000_0038);
      wr(A_STS, 32'h0000_0038);
      rd_check("R8 cleared", A_STS, 32'h0);

      // R9: summary bit follows error causes
      ev_err = 8'h05; step(); ev_err = '0;
      rd_check("R9 summary set", A_STS, 32'h0005_8000);
      wr(A_STS, 32'h0001_0000);
      rd_check("R9 one cause left", A_STS, 32'h0004_8000);
      wr(A_STS, 32'h0000_8000);
      rd_check("R8 bit15 write no effect", A_STS, 32'h0004_8000);

      // R10: interrupt masking
      check("R10 masked", {31'h0, irq}, 32'h0);
      wr(A_SIGEN, 32'h0000_8000);
      check("R10 summary irq", {31'h0, irq}, 32'h1);
      wr(A_STS, 32'h0004_0000);
      rd_check("R9 summary cleared", A_STS, 32'h0);
      check("R10 irq drops", {31'h0, irq}, 32'h0);
      wr(A_STSEN, LATCH_ALL & ~32'h0002_0000);
      ev_err = 8'h02; step(); ev_err = '0;
      rd_check("R9 disabled cause no summary", A_STS, 32'h0);
      wr(A_SIGEN, 32'h0000_0001);
      ev_cmd_done = 1'b1; step(); ev_cmd_done = 1'b0;
      check("R10 cmd irq", {31'h0, irq}, 32'h1);

      // R11: software reset
      wr(A_CMD, 32'h0000_0722);
      wr(A_SRST, 32'h1);
      rd_check("R11 bit reads 1", A_SRST, 32'h1);
      wr(A_XFER, 32'h0000_0001);
      rd_check("R11 still busy", A_SRST, 32'h1);
      repeat (RST_CYCLES - 2) step();
      rd_check("R11 last busy cycle", A_SRST, 32'h1);
      step();
      rd_check("R11 self cleared", A_SRST, 32'h0);
      rd_check("R11 xfer reset, write ignored", A_XFER, 32'h0);
      rd_check("R11 cmd reset", A_CMD, 32'h0);
      rd_check("R11 blk reset", A_BLK, 32'h0);
      rd_check("R11 pres reset", A_PRES, 32'h0050_0000);
      rd_check("R11 status reset", A_STS, 32'h0);
      rd_check("R11 sig_en reset", A_SIGEN, 32'h0);
      check("R11 irq low", {31'h0, irq}, 32'h0);
      wr(A_CMD, 32'h0000_0300);
      check("R11 command accepted after", {31'h0, cmd_start}, 32'h1);

      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

endmodule